// File: doc/BRIEF.md
# Sigma-Delta Comparator ADC Controller

This block runs the digital half of a first-order sigma-delta converter. An external comparator watches an RC integrator. The integrator is charged through a single feedback output of this block. On every sample tick the controller drives the feedback bit to the inverse of the comparator reading, which closes the loop. It also counts how many ticks left the feedback bit high during a conversion window. Over a long window, the density of high feedback tracks the analog input level.

A sequence counter frames each window. After reset the counter starts at zero. Ticks taken while its top bit is clear add to the tally. The tick that finds the top bit set closes the window. It moves the tally into the result register, clears the tally and reloads the counter so that it wraps to zero. A window therefore spans 129 ticks, and 128 of them can add to the count. At each window close the block also pulses a result-valid strobe and a period strobe, and flips a test toggle that can be watched on a scope. The raw comparator bit passes through a two-flop synchronizer before it is used. The tick is expected to be a single-clock pulse from a timebase elsewhere in the chip.

Top module: `sd_adc_ctrl`

## Requirements
- R1: The comparator input is sampled through a two-stage synchronizer. A level held on `cmp_in` for at least two clocks before a tick is the level that tick uses.
- R2: On the clock edge that samples `tick` high, `fb_out` becomes the inverse of the synchronized comparator level: 0 when the comparator reads 1, and 1 when it reads 0.
- R3: A tick that does not close the window adds one to the tally when the newly set feedback bit is 1, and leaves the tally alone when it is 0.
- R4: After reset, and after every window close, exactly 128 ticks accumulate. The 129th tick closes the window.
- R5: A closing tick loads the tally into `result` and restarts the tally from zero, so consecutive windows are independent. `result` changes only on the clock in which `result_valid` is high.
- R6: `result_valid` is high for exactly one clock, the one after the edge of the closing tick.
- R7: Each window close pulses `period_strobe` for one clock, together with `result_valid`, and inverts `test_toggle`.
- R8: While `rst` is high at a clock edge, the tally, `result` and the sequence counter clear. `fb_out`, `test_toggle`, `result_valid` and `period_strobe` go low.
- R9: The tally saturates at 128. A window whose feedback is high on every tick yields 128, and `result` never exceeds 128.
- R10: A clock without a tick changes none of `fb_out`, the tally or the window position, whatever `cmp_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock sample tick |
| cmp_in | input | 1 | Raw comparator output, asynchronous |
| fb_out | output | 1 | Feedback bit to the RC integrator |
| result | output | 8 | Count from the last completed window |
| result_valid | output | 1 | One-clock pulse when `result` is loaded |
| test_toggle | output | 1 | Inverts at every window close |
| period_strobe | output | 1 | One-clock pulse at every window close |

## Verification
A comparator change needs two edges to pass the synchronizer. The bench therefore changes `cmp_in` only between ticks, and holds the new level for three clocks before it raises `tick`. The feedback bit, the result, both strobes and the toggle all update on the single edge that samples the tick. The bench checks them on the falling edge that follows that edge, and checks again one falling edge later that both strobes have dropped. It models the window position and the tally per tick, so it expects the close exactly at the 129th tick. It runs windows with all-high and all-low feedback, alternating feedback and random density, and it makes comparator-only changes to show they have no effect.

// File: rtl/sd_adc_pkg.sv
package sd_adc_pkg;

    localparam int unsigned DEF_SEQ_W  = 8;
    localparam int unsigned DEF_RES_W  = 8;
    localparam int unsigned DEF_SYNC_N = 2;

    // Position of a tick inside the conversion window
    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_CLOSE  = 1'b1
    } win_phase_e;

    // Everything the tally needs to know about one clock
    typedef struct packed {
        logic       strobe;
        logic       fb;
        win_phase_e phase;
    } tick_evt_t;

    function automatic win_phase_e phase_of(input logic top_bit);
        return top_bit ? PH_CLOSE : PH_SAMPLE;
    endfunction

endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sd_window_seq.sv
module sd_window_seq
    import sd_adc_pkg::*;
#(
    parameter int unsigned SEQ_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    output win_phase_e phase
);
    logic [SEQ_W-1:0] seq;
    logic [SEQ_W-1:0] seq_base;

    assign phase    = phase_of(seq[SEQ_W-1]);
    // A close loads all-ones; the common increment then wraps it to zero
    assign seq_base = (phase == PH_CLOSE) ? '1 : seq;

    always_ff @(posedge clk) begin
        if (rst)       seq <= '0;
        else if (tick) seq <= seq_base + SEQ_W'(1);
    end
endmodule

// File: rtl/sd_tally.sv
module sd_tally
    import sd_adc_pkg::*;
#(
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tick_evt_t        evt,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);
    localparam int unsigned      ACC_TICKS = 2 ** (SEQ_W - 1);
    localparam logic [RES_W-1:0] CAP       = RES_W'(ACC_TICKS);

    logic [RES_W-1:0] acc;

    function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
        return (v >= CAP) ? CAP : v + RES_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            acc          <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (evt.strobe) begin
                if (evt.phase == PH_CLOSE) begin
                    result       <= acc;
                    acc          <= '0;
                    result_valid <= 1'b1;
                end else if (evt.fb) begin
                    acc <= sat_inc(acc);
                end
            end
        end
    end
endmodule

// File: rtl/sd_adc_ctrl.sv
module sd_adc_ctrl
    import sd_adc_pkg::*;
#(
    parameter int unsigned SEQ_W  = DEF_SEQ_W,
    parameter int unsigned RES_W  = DEF_RES_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             fb_out,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             test_toggle,
    output logic             period_strobe
);
    logic       cmp_s;
    logic       fb_next;
    win_phase_e phase;
    tick_evt_t  evt;

    sd_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (cmp_in),
        .d_out (cmp_s)
    );

    sd_window_seq #(.SEQ_W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (phase)
    );

    assign fb_next = ~cmp_s;
    assign evt     = '{strobe: tick, fb: fb_next, phase: phase};

    sd_tally #(.SEQ_W(SEQ_W), .RES_W(RES_W)) u_tally (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .result       (result),
        .result_valid (result_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_out        <= 1'b0;
            test_toggle   <= 1'b0;
            period_strobe <= 1'b0;
        end else begin
            period_strobe <= 1'b0;
            if (tick) begin
                fb_out <= fb_next;
                if (phase == PH_CLOSE) begin
                    test_toggle   <= ~test_toggle;
                    period_strobe <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sd_adc_ctrl_chk.sv
module sd_adc_ctrl_chk #(
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned RES_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cmp_s,
    input logic             fb_out,
    input logic [RES_W-1:0] result,
    input logic             result_valid,
    input logic             test_toggle,
    input logic             period_strobe
);
    localparam logic [RES_W-1:0] CAP = RES_W'(2 ** (SEQ_W - 1));

    // R2
    fb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (fb_out == !$past(cmp_s)));

    // R10
    fb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(fb_out));

    // R10
    no_event_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (!result_valid && !period_strobe));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |=> (result_valid || $stable(result)));

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        period_strobe |-> (test_toggle != $past(test_toggle)));

    // R7
    strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> period_strobe);

    // R9
    result_cap_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (result <= CAP));
endmodule

bind sd_adc_ctrl sd_adc_ctrl_chk #(.SEQ_W(SEQ_W), .RES_W(RES_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .cmp_s         (cmp_s),
    .fb_out        (fb_out),
    .result        (result),
    .result_valid  (result_valid),
    .test_toggle   (test_toggle),
    .period_strobe (period_strobe)
);

// File: tb/sd_adc_ctrl_test.sv
module sd_adc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cmp_in = 1'b0;
    logic       fb_out;
    logic [7:0] result;
    logic       result_valid;
    logic       test_toggle;
    logic       period_strobe;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int seq_m = 0;
    int acc_m = 0;
    bit tog_m = 1'b0;

    always #2.5 clk = ~clk;

    sd_adc_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .cmp_in        (cmp_in),
        .fb_out        (fb_out),
        .result        (result),
        .result_valid  (result_valid),
        .test_toggle   (test_toggle),
        .period_strobe (period_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_acc(input int a, input bit fb);
        if (!fb) return a;
        return (a >= 128) ? 128 : a + 1;
    endfunction

    // Apply one tick with comparator level c and check every output
    task automatic do_tick(input bit c);
        bit closing;
        bit fb_exp;
        int res_exp;
        @(negedge clk);
        cmp_in = c;
        repeat (3) @(negedge clk);       // R1: two synchronizer edges plus margin
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        fb_exp  = !c;
        closing = (seq_m >= 128);
        res_exp = acc_m;
        if (closing) begin
            acc_m = 0;
            seq_m = 0;
            tog_m = !tog_m;
        end else begin
            acc_m = next_acc(acc_m, fb_exp);
            seq_m = seq_m + 1;
        end
        check(fb_out == fb_exp, "R2 fb inverse", int'(fb_out), int'(fb_exp));
        if (closing) begin
            check(result_valid == 1'b1, "R4 window close at 129th tick", int'(result_valid), 1);
            check(int'(result) == res_exp, "R5 result latch", int'(result), res_exp);
            check(period_strobe == 1'b1, "R7 period strobe", int'(period_strobe), 1);
            check(test_toggle == tog_m, "R7 toggle", int'(test_toggle), int'(tog_m));
            @(negedge clk);
            check(result_valid == 1'b0, "R6 valid one clock", int'(result_valid), 0);
            check(period_strobe == 1'b0, "R7 strobe one clock", int'(period_strobe), 0);
        end else begin
            if (result_valid !== 1'b0)
                check(1'b0, "R3 no valid mid-window", int'(result_valid), 0);
        end
    endtask

    // One full window: mode 0 all comparator low, 1 all high, 2 alternate, 3 random density
    task automatic run_window(input int mode, input int dens);
        for (int i = 0; i < 129; i++) begin
            bit c;
            case (mode)
                0: c = 1'b0;
                1: c = 1'b1;
                2: c = i[0];
                default: c = (($urandom % 256) >= dens);
            endcase
            do_tick(c);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8 reset state
        check(fb_out == 1'b0, "R8 fb reset", int'(fb_out), 0);
        check(result == 8'd0, "R8 result reset", int'(result), 0);
        check(result_valid == 1'b0, "R8 valid reset", int'(result_valid), 0);
        check(test_toggle == 1'b0, "R8 toggle reset", int'(test_toggle), 0);
        check(period_strobe == 1'b0, "R8 strobe reset", int'(period_strobe), 0);
        rst = 1'b0;
        @(negedge clk);

        // R9 every tick with feedback high: expect 128
        run_window(0, 0);
        check(int'(result) == 128, "R9 saturation full scale", int'(result), 128);
        // R5 all feedback low right after: fresh window gives 0
        run_window(1, 0);
        check(int'(result) == 0, "R5 independent window", int'(result), 0);
        // R3 alternating gives half
        run_window(2, 0);
        check(int'(result) == 64, "R3 alternating count", int'(result), 64);

        // R10 comparator wiggles without tick leave fb and window alone
        begin
            logic fb_before;
            fb_before = fb_out;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                cmp_in = ~cmp_in;
                @(negedge clk);
                check(fb_out == fb_before, "R10 no tick no change", int'(fb_out), int'(fb_before));
                check(result_valid == 1'b0, "R10 no spurious valid", int'(result_valid), 0);
            end
        end

        // R4 random density windows, window position continues from model
        for (int w = 0; w < 5; w++) run_window(3, int'($urandom % 256));

        // R8 reset mid-window restarts framing
        for (int i = 0; i < 10; i++) do_tick(1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seq_m = 0; acc_m = 0; tog_m = 1'b0;
        check(result == 8'd0, "R8 result cleared", int'(result), 0);
        check(test_toggle == 1'b0, "R8 toggle cleared", int'(test_toggle), 0);
        run_window(0, 0);
        check(int'(result) == 128, "R4 framing after reset", int'(result), 128);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule